// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block sits beside a processor core and handles the memory side of taking an exception or returning from one. When an exception or a hardware interrupt is requested, it updates the status word and picks the supervisor stack. It then writes a stack frame through a single memory port, one access at a time. The frame layout depends on the exception number. Finally it reads the handler address from the vector table and presents it together with the new status word and the updated stack pointers. On a return request it reads the saved status word, program counter and format word back from the active stack. It then drops whatever extra words that format carries, and hands the restored state back to the core.

Three stack pointers enter and leave the block: user, interrupt and master. The status word selects among them. The supervisor bit picks the user stack when clear. When the supervisor bit is set, the master bit chooses between the master and interrupt stacks. A hardware interrupt that arrives while the master stack is active writes two frames, one on each supervisor stack. A parameter removes the format word and the extra words for a minimal core, and another parameter keeps or clears the low bit of the stack pointer before a push.

Top module: `exc_frame_seq`

## Requirements
- R1: On entry the new status word keeps the old one but has the supervisor bit (bit 13) set and the trace bit (bit 15) cleared. For a hardware interrupt its mask field (bits 10:8) is loaded with the pending level.
- R2: A hardware interrupt is taken only when its level is strictly greater than the current mask. Otherwise the block pulses `done` with `taken` low, makes no memory access and leaves every output unchanged.
- R3: A frame is written downward from the stack pointer. From high address to low it holds the extra longwords, a 16-bit word equal to (format << 12) + vector × 4, the 32-bit return PC, and the 16-bit old status word at the lowest address. The stack output ends at that lowest address. Memory is big-endian.
- R4: Vectors 5, 6, 7 and 9 use format 2, whose extra longword is the fault address input. Vector 3 uses format 2 with an extra longword of zero.
- R5: The vector given by parameter `FMT4_VEC` (default 11) uses format 4. Its extra longwords are the current PC at the higher address and the fault address below it.
- R6: Every other vector uses format 0, which has no extra words.
- R7: With `ODD_SP_OK` = 0, bit 0 of the stack pointer is cleared before the first push on each stack.
- R8: A hardware interrupt taken while the master bit (bit 12) is set writes a format 0 frame holding the old status word on the master stack. It then writes a format 1 frame holding the new status word (master bit still set) on the interrupt stack. The final status word has the master bit clear.
- R9: After the frame is written, the new PC is read as a longword from vector base + vector × 4. `done` pulses for exactly one cycle while `pc_out` holds that value.
- R10: A return reads the status word, the PC and the format word, in that order, from the stack selected by `sr_in`. It then skips 4 more bytes for formats 2 and 3, 8 for format 4, 52 for format 7 and none otherwise. The final pointer is written back to that stack, and `sr_out` and `pc_out` take the popped values.
- R11: On return, format 1 writes the stack pointer back, loads the popped status word and restarts the unwind from the stack that status word selects.
- R12: Only one access is outstanding at a time. Address, data, direction and size hold steady while `mem_req` is high and `mem_ready` is low. After reset the block is idle with all outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, one cycle while idle |
| req_rte | input | 1 | Request is a return from exception |
| req_hw | input | 1 | Request is a hardware interrupt |
| req_level | input | 3 | Pending interrupt level |
| req_vec | input | 8 | Exception vector number |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Current / return program counter |
| usp_in | input | 32 | User stack pointer |
| isp_in | input | 32 | Interrupt stack pointer |
| msp_in | input | 32 | Master stack pointer |
| vbr_in | input | 32 | Vector table base |
| fault_addr_in | input | 32 | Instruction or fault address for extra frame words |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit access, 0 = 16-bit access (data in bits 15:0) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Request was carried out (0 = interrupt declined) |
| sr_out | output | 16 | Resulting status word |
| pc_out | output | 32 | Resulting program counter |
| usp_out | output | 32 | Resulting user stack pointer |
| isp_out | output | 32 | Resulting interrupt stack pointer |
| msp_out | output | 32 | Resulting master stack pointer |

## Verification
The directed cases cover every frame format on entry and every skip distance on return. A wrong skip table would leave the interrupt stack pointer off by a multiple of four. The two-frame interrupt case checks both stacks. A design that forgot to clear the master bit, or that wrote the format 1 frame with the old status word, would leave the wrong word at the bottom of the interrupt stack. Interrupts at a level equal to the mask, including level 7 against mask 7, must be declined with no write reaching memory. An odd starting stack pointer and a memory that inserts wait states expose designs that misalign frames or let the address wander before `mem_ready`.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

    localparam int AW     = 32;
    localparam int SRW    = 16;
    localparam int VECW   = 8;
    localparam int FMTW   = 4;
    localparam int STEPW  = 3;
    localparam int NSTK   = 3;

    // status word fields
    localparam int SR_T   = 15;
    localparam int SR_S   = 13;
    localparam int SR_M   = 12;
    localparam int SR_IPL = 8;   // low bit of the 3-bit mask field

    localparam logic [1:0] STK_USER   = 2'd0;
    localparam logic [1:0] STK_INT    = 2'd1;
    localparam logic [1:0] STK_MASTER = 2'd2;

    // last push step of a frame: the status word
    localparam logic [STEPW-1:0] LAST_STEP = 3'd4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH,
        SQ_VEC,
        SQ_POP_SR,
        SQ_POP_PC,
        SQ_POP_FMT,
        SQ_FIN
    } seq_state_t;

    typedef struct packed {
        logic          used;
        logic          is_long;
        logic [AW-1:0] data;
    } push_op_t;

    function automatic logic [1:0] stack_of(input logic [SRW-1:0] sr);
        if (!sr[SR_S])     return STK_USER;
        else if (sr[SR_M]) return STK_MASTER;
        else               return STK_INT;
    endfunction

    function automatic logic [FMTW-1:0] fmt_for_vec(input logic [VECW-1:0] vec,
                                                    input logic [VECW-1:0] fmt4_vec);
        if (vec == fmt4_vec) return 4'd4;
        case (vec)
            8'd3, 8'd5, 8'd6, 8'd7, 8'd9: return 4'd2;
            default:                      return 4'd0;
        endcase
    endfunction

    function automatic logic [7:0] unwind_skip(input logic [FMTW-1:0] fmt);
        case (fmt)
            4'd2, 4'd3: return 8'd4;
            4'd4:       return 8'd8;
            4'd7:       return 8'd52;
            default:    return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_sr_entry.sv
module exc_sr_entry
    import exc_frame_pkg::*;
(
    input  logic [SRW-1:0] old_sr,
    input  logic           hw,
    input  logic [2:0]     level,
    output logic [SRW-1:0] new_sr,
    output logic           accept
);
    always_comb begin
        new_sr        = old_sr;
        new_sr[SR_S]  = 1'b1;
        new_sr[SR_T]  = 1'b0;
        if (hw) new_sr[SR_IPL+2:SR_IPL] = level;
    end

    assign accept = !hw || (level > old_sr[SR_IPL+2:SR_IPL]);
endmodule

// File: rtl/exc_push_plan.sv
module exc_push_plan
    import exc_frame_pkg::*;
#(
    parameter bit HAS_FMT_WORD = 1'b1
) (
    input  logic [FMTW-1:0]  fmt,
    input  logic [STEPW-1:0] step,
    input  logic [VECW-1:0]  vec,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    extra,
    input  logic [SRW-1:0]   sr,
    output push_op_t         op
);
    always_comb begin
        op = '0;
        case (step)
            3'd0: begin
                if (HAS_FMT_WORD && fmt == 4'd2) begin
                    op.used = 1'b1; op.is_long = 1'b1; op.data = extra;
                end else if (HAS_FMT_WORD && fmt == 4'd4) begin
                    op.used = 1'b1; op.is_long = 1'b1; op.data = pc;
                end
            end
            3'd1: begin
                if (HAS_FMT_WORD && fmt == 4'd4) begin
                    op.used = 1'b1; op.is_long = 1'b1; op.data = extra;
                end
            end
            3'd2: begin
                if (HAS_FMT_WORD) begin
                    op.used = 1'b1; op.is_long = 1'b0;
                    op.data = {16'h0000, fmt, 2'b00, vec, 2'b00};
                end
            end
            3'd3: begin
                op.used = 1'b1; op.is_long = 1'b1; op.data = pc;
            end
            3'd4: begin
                op.used = 1'b1; op.is_long = 1'b0; op.data = {16'h0000, sr};
            end
            default: op = '0;
        endcase
    end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter bit              HAS_FMT_WORD = 1'b1,
    parameter bit              ODD_SP_OK    = 1'b0,
    parameter logic [VECW-1:0] FMT4_VEC     = 8'd11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_rte,
    input  logic            req_hw,
    input  logic [2:0]      req_level,
    input  logic [VECW-1:0] req_vec,
    input  logic [SRW-1:0]  sr_in,
    input  logic [AW-1:0]   pc_in,
    input  logic [AW-1:0]   usp_in,
    input  logic [AW-1:0]   isp_in,
    input  logic [AW-1:0]   msp_in,
    input  logic [AW-1:0]   vbr_in,
    input  logic [AW-1:0]   fault_addr_in,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_long,
    output logic [AW-1:0]   mem_addr,
    output logic [AW-1:0]   mem_wdata,
    input  logic [AW-1:0]   mem_rdata,
    input  logic            mem_ready,
    output logic            done,
    output logic            taken,
    output logic [SRW-1:0]  sr_out,
    output logic [AW-1:0]   pc_out,
    output logic [AW-1:0]   usp_out,
    output logic [AW-1:0]   isp_out,
    output logic [AW-1:0]   msp_out
);
    seq_state_t       st;
    logic [STEPW-1:0] step_r;
    logic [FMTW-1:0]  fmt_r;
    logic             second_r;
    logic [SRW-1:0]   frame_sr_r;
    logic [SRW-1:0]   cur_sr;
    logic [SRW-1:0]   pop_sr_r;
    logic [AW-1:0]    sp_w;
    logic [AW-1:0]    pc_r;
    logic [AW-1:0]    pcin_r;
    logic [AW-1:0]    extra_r;
    logic [AW-1:0]    vbr_r;
    logic [VECW-1:0]  vec_r;
    logic             taken_r;
    logic [AW-1:0]    stk_r [NSTK];

    logic [SRW-1:0]   entry_sr;
    logic             entry_ok;
    push_op_t         op;
    logic [AW-1:0]    push_addr;
    logic             xfer;
    logic [AW-1:0]    pop_after;

    function automatic logic [AW-1:0] align_sp(input logic [AW-1:0] sp);
        return ODD_SP_OK ? sp : {sp[AW-1:1], 1'b0};
    endfunction

    function automatic logic [AW-1:0] pick_in(input logic [1:0] idx,
                                              input logic [AW-1:0] u,
                                              input logic [AW-1:0] i,
                                              input logic [AW-1:0] m);
        case (idx)
            STK_USER:   return u;
            STK_MASTER: return m;
            default:    return i;
        endcase
    endfunction

    exc_sr_entry u_sr_entry (
        .old_sr (sr_in),
        .hw     (req_hw),
        .level  (req_level),
        .new_sr (entry_sr),
        .accept (entry_ok)
    );

    exc_push_plan #(.HAS_FMT_WORD(HAS_FMT_WORD)) u_plan (
        .fmt   (fmt_r),
        .step  (step_r),
        .vec   (vec_r),
        .pc    (pcin_r),
        .extra (extra_r),
        .sr    (frame_sr_r),
        .op    (op)
    );

    assign push_addr = sp_w - (op.is_long ? 32'd4 : 32'd2);
    assign pop_after = sp_w + 32'd2;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_long  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            SQ_PUSH: begin
                mem_req   = op.used;
                mem_we    = 1'b1;
                mem_long  = op.is_long;
                mem_addr  = push_addr;
                mem_wdata = op.data;
            end
            SQ_VEC: begin
                mem_req  = 1'b1;
                mem_long = 1'b1;
                mem_addr = vbr_r + {22'd0, vec_r, 2'b00};
            end
            SQ_POP_SR, SQ_POP_FMT: begin
                mem_req  = 1'b1;
                mem_addr = sp_w;
            end
            SQ_POP_PC: begin
                mem_req  = 1'b1;
                mem_long = 1'b1;
                mem_addr = sp_w;
            end
            default: ;
        endcase
    end

    assign xfer = mem_req && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            step_r     <= '0;
            fmt_r      <= '0;
            second_r   <= 1'b0;
            frame_sr_r <= '0;
            cur_sr     <= '0;
            pop_sr_r   <= '0;
            sp_w       <= '0;
            pc_r       <= '0;
            pcin_r     <= '0;
            extra_r    <= '0;
            vbr_r      <= '0;
            vec_r      <= '0;
            taken_r    <= 1'b0;
            for (int k = 0; k < NSTK; k++) stk_r[k] <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (req_valid) begin
                    vec_r  <= req_vec;
                    pcin_r <= pc_in;
                    vbr_r  <= vbr_in;
                    if (req_rte) begin
                        stk_r[STK_USER]   <= usp_in;
                        stk_r[STK_INT]    <= isp_in;
                        stk_r[STK_MASTER] <= msp_in;
                        cur_sr  <= sr_in;
                        sp_w    <= pick_in(stack_of(sr_in), usp_in, isp_in, msp_in);
                        taken_r <= 1'b1;
                        st      <= SQ_POP_SR;
                    end else if (!entry_ok) begin
                        taken_r <= 1'b0;
                        st      <= SQ_FIN;
                    end else begin
                        stk_r[STK_USER]   <= usp_in;
                        stk_r[STK_INT]    <= isp_in;
                        stk_r[STK_MASTER] <= msp_in;
                        cur_sr     <= entry_sr;
                        sp_w       <= align_sp(pick_in(stack_of(entry_sr), usp_in, isp_in, msp_in));
                        extra_r    <= (req_vec == 8'd3) ? '0 : fault_addr_in;
                        frame_sr_r <= sr_in;
                        step_r     <= '0;
                        taken_r    <= 1'b1;
                        if (req_hw && sr_in[SR_M]) begin
                            second_r <= 1'b1;
                            fmt_r    <= 4'd0;
                        end else begin
                            second_r <= 1'b0;
                            fmt_r    <= HAS_FMT_WORD ? fmt_for_vec(req_vec, FMT4_VEC) : 4'd0;
                        end
                        st <= SQ_PUSH;
                    end
                end
                SQ_PUSH: if (!op.used || xfer) begin
                    if (op.used) sp_w <= push_addr;
                    if (step_r == LAST_STEP) begin
                        stk_r[stack_of(cur_sr)] <= push_addr;
                        if (second_r) begin
                            cur_sr[SR_M] <= 1'b0;
                            sp_w         <= align_sp(stk_r[STK_INT]);
                            frame_sr_r   <= cur_sr;
                            fmt_r        <= HAS_FMT_WORD ? 4'd1 : 4'd0;
                            second_r     <= 1'b0;
                            step_r       <= '0;
                        end else begin
                            st <= SQ_VEC;
                        end
                    end else begin
                        step_r <= step_r + 3'd1;
                    end
                end
                SQ_VEC: if (xfer) begin
                    pc_r <= mem_rdata;
                    st   <= SQ_FIN;
                end
                SQ_POP_SR: if (xfer) begin
                    pop_sr_r <= mem_rdata[SRW-1:0];
                    sp_w     <= pop_after;
                    st       <= SQ_POP_PC;
                end
                SQ_POP_PC: if (xfer) begin
                    pc_r <= mem_rdata;
                    if (HAS_FMT_WORD) begin
                        sp_w <= sp_w + 32'd4;
                        st   <= SQ_POP_FMT;
                    end else begin
                        stk_r[stack_of(cur_sr)] <= sp_w + 32'd4;
                        cur_sr <= pop_sr_r;
                        st     <= SQ_FIN;
                    end
                end
                SQ_POP_FMT: if (xfer) begin
                    cur_sr <= pop_sr_r;
                    if (mem_rdata[15:12] == 4'd1) begin
                        stk_r[stack_of(cur_sr)] <= pop_after;
                        sp_w <= (stack_of(pop_sr_r) == stack_of(cur_sr)) ? pop_after
                                                                        : stk_r[stack_of(pop_sr_r)];
                        st   <= SQ_POP_SR;
                    end else begin
                        stk_r[stack_of(cur_sr)] <= pop_after + {24'd0, unwind_skip(mem_rdata[15:12])};
                        st <= SQ_FIN;
                    end
                end
                SQ_FIN: st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign done    = (st == SQ_FIN);
    assign taken   = taken_r;
    assign sr_out  = cur_sr;
    assign pc_out  = pc_r;
    assign usp_out = stk_r[STK_USER];
    assign isp_out = stk_r[STK_INT];
    assign msp_out = stk_r[STK_MASTER];

    // R12: a pending access holds every attribute until accepted
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                  && $stable(mem_we) && $stable(mem_long));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: a declined interrupt finishes at once with no memory traffic
    a_r2_decline_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE) && req_valid && !req_rte && req_hw
        && (req_level <= sr_in[SR_IPL+2:SR_IPL]) |=> done && !taken && !mem_req);

    // R1: every frame write happens in supervisor mode with tracing off
    a_r1_super_on_push: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> sr_out[SR_S] && !sr_out[SR_T]);

    // R7: pushes stay on even addresses when odd stacks are not allowed
    a_r7_even_push: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && !ODD_SP_OK |-> !mem_addr[0]);

endmodule

// File: tb/test_exc_frame_seq.sv
`timescale 1ns/1ps
module test_exc_frame_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_rte = 1'b0, req_hw = 1'b0;
    logic [2:0]  req_level = '0;
    logic [7:0]  req_vec = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc_in = '0, usp_in = '0, isp_in = '0, msp_in = '0;
    logic [31:0] vbr_in = 32'h100, fault_addr_in = '0;
    logic        mem_req, mem_we, mem_long, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, taken;
    logic [15:0] sr_out;
    logic [31:0] pc_out, usp_out, isp_out, msp_out;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    int hold_err = 0;

    logic [7:0]  mem [4096];
    logic [1:0]  wait_cnt = '0;
    logic [1:0]  wait_pat = '0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0, prev_wdata = '0;
    logic        prev_we = 1'b0;

    always #2.5 clk = ~clk;

    exc_frame_seq i_exc_frame_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rte(req_rte),
        .req_hw(req_hw), .req_level(req_level), .req_vec(req_vec),
        .sr_in(sr_in), .pc_in(pc_in), .usp_in(usp_in), .isp_in(isp_in),
        .msp_in(msp_in), .vbr_in(vbr_in), .fault_addr_in(fault_addr_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done), .taken(taken), .sr_out(sr_out),
        .pc_out(pc_out), .usp_out(usp_out), .isp_out(isp_out), .msp_out(msp_out)
    );

    function automatic logic [11:0] ix(input logic [31:0] a, input int k);
        return 12'(a[11:0] + 12'(k));
    endfunction

    assign mem_ready = mem_req && (wait_cnt == 2'd0);
    assign mem_rdata = mem_long ? {mem[ix(mem_addr,0)], mem[ix(mem_addr,1)],
                                   mem[ix(mem_addr,2)], mem[ix(mem_addr,3)]}
                                : {16'h0000, mem[ix(mem_addr,0)], mem[ix(mem_addr,1)]};

    // memory model with varying wait states and a hold monitor
    always @(posedge clk) begin
        if (prev_pend && (mem_addr != prev_addr || mem_wdata != prev_wdata
                          || mem_we != prev_we || !mem_req))
            hold_err <= hold_err + 1;
        prev_pend  <= mem_req && !mem_ready;
        prev_addr  <= mem_addr;
        prev_wdata <= mem_wdata;
        prev_we    <= mem_we;
        if (mem_req) begin
            if (wait_cnt == 2'd0) begin
                if (mem_we) begin
                    writes <= writes + 1;
                    if (mem_long) begin
                        mem[ix(mem_addr,0)] <= mem_wdata[31:24];
                        mem[ix(mem_addr,1)] <= mem_wdata[23:16];
                        mem[ix(mem_addr,2)] <= mem_wdata[15:8];
                        mem[ix(mem_addr,3)] <= mem_wdata[7:0];
                    end else begin
                        mem[ix(mem_addr,0)] <= mem_wdata[15:8];
                        mem[ix(mem_addr,1)] <= mem_wdata[7:0];
                    end
                end
                wait_pat <= (wait_pat == 2'd2) ? 2'd0 : wait_pat + 2'd1;
                wait_cnt <= wait_pat;
            end else begin
                wait_cnt <= wait_cnt - 2'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    endtask

    task automatic wr32(input logic [31:0] a, input logic [31:0] d);
        mem[ix(a,0)] = d[31:24]; mem[ix(a,1)] = d[23:16];
        mem[ix(a,2)] = d[15:8];  mem[ix(a,3)] = d[7:0];
    endtask

    task automatic wr16(input logic [31:0] a, input logic [15:0] d);
        mem[ix(a,0)] = d[15:8]; mem[ix(a,1)] = d[7:0];
    endtask

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {mem[ix(a,0)], mem[ix(a,1)], mem[ix(a,2)], mem[ix(a,3)]};
    endfunction

    function automatic logic [31:0] rd16(input logic [31:0] a);
        return {16'h0000, mem[ix(a,0)], mem[ix(a,1)]};
    endfunction

    task automatic fire(input logic rte, input logic hw, input logic [2:0] lvl,
                        input logic [7:0] vec, input logic [15:0] sr,
                        input logic [31:0] pc, input logic [31:0] usp,
                        input logic [31:0] isp, input logic [31:0] msp,
                        input logic [31:0] fault);
        int n;
        @(negedge clk);
        req_rte = rte; req_hw = hw; req_level = lvl; req_vec = vec;
        sr_in = sr; pc_in = pc; usp_in = usp; isp_in = isp; msp_in = msp;
        fault_addr_in = fault; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R9 completion seen", {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12 reset done", {31'd0, done}, 32'd0);
        chk("R12 reset pc_out", pc_out, 32'd0);
        chk("R12 reset sr_out", {16'd0, sr_out}, 32'd0);
    endtask

    task automatic t_trap();
        clr_mem();
        wr32(32'h180, 32'h0000_4000);
        fire(0, 0, 0, 8'd32, 16'h0004, 32'h1234_5678, 32'h500, 32'h900, 32'hA00, 32'h0);
        chk("R6 fmt word", rd16(32'h8FE), 32'h0080);
        chk("R3 return pc", rd32(32'h8FA), 32'h1234_5678);
        chk("R3 old sr", rd16(32'h8F8), 32'h0004);
        chk("R3 isp_out", isp_out, 32'h8F8);
        chk("R3 usp kept", usp_out, 32'h500);
        chk("R1 new sr", {16'd0, sr_out}, 32'h2004);
        chk("R9 vector pc", pc_out, 32'h4000);
        chk("R9 taken", {31'd0, taken}, 32'd1);
        @(negedge clk);
        chk("R9 done single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic t_div0();
        clr_mem();
        wr32(32'h114, 32'h0000_3000);
        fire(0, 0, 0, 8'd5, 16'hA700, 32'h2000, 32'h500, 32'h900, 32'hA00, 32'hCAFE_0000);
        chk("R4 extra fault addr", rd32(32'h8FC), 32'hCAFE_0000);
        chk("R4 fmt2 word", rd16(32'h8FA), 32'h2014);
        chk("R4 pc", rd32(32'h8F6), 32'h2000);
        chk("R4 old sr", rd16(32'h8F4), 32'hA700);
        chk("R4 isp_out", isp_out, 32'h8F4);
        chk("R1 trace cleared", {16'd0, sr_out}, 32'h2700);
        chk("R9 pc_out", pc_out, 32'h3000);
    endtask

    task automatic t_addr_err();
        clr_mem();
        wr32(32'h10C, 32'h0000_0C00);
        fire(0, 0, 0, 8'd3, 16'h2000, 32'h2222, 32'h500, 32'h901, 32'hA00, 32'hFFFF_FFFF);
        chk("R4 addr err extra zero", rd32(32'h8FC), 32'h0);
        chk("R7 fmt word aligned", rd16(32'h8FA), 32'h200C);
        chk("R7 isp_out aligned", isp_out, 32'h8F4);
    endtask

    task automatic t_fmt4();
        clr_mem();
        wr32(32'h12C, 32'h0000_0D00);
        fire(0, 0, 0, 8'd11, 16'h2000, 32'h4444_0000, 32'h500, 32'h900, 32'hA00, 32'h5555_0000);
        chk("R5 current pc high", rd32(32'h8FC), 32'h4444_0000);
        chk("R5 fault addr", rd32(32'h8F8), 32'h5555_0000);
        chk("R5 fmt4 word", rd16(32'h8F6), 32'h402C);
        chk("R5 isp_out", isp_out, 32'h8F0);
    endtask

    task automatic t_decline();
        logic [31:0] pc_before, isp_before;
        int w0;
        pc_before = pc_out; isp_before = isp_out; w0 = writes;
        fire(0, 1, 3'd3, 8'd27, 16'h2300, 32'h7777, 32'h500, 32'h900, 32'hA00, 32'h0);
        chk("R2 equal level declined", {31'd0, taken}, 32'd0);
        chk("R2 no writes", writes - w0, 32'd0);
        chk("R2 pc unchanged", pc_out, pc_before);
        chk("R2 isp unchanged", isp_out, isp_before);
        fire(0, 1, 3'd7, 8'd31, 16'h2700, 32'h7777, 32'h500, 32'h900, 32'hA00, 32'h0);
        chk("R2 level 7 vs mask 7 declined", {31'd0, taken}, 32'd0);
        chk("R2 no writes level 7", writes - w0, 32'd0);
    endtask

    task automatic t_hw();
        clr_mem();
        wr32(32'h174, 32'h0000_0E00);
        fire(0, 1, 3'd5, 8'd29, 16'h2200, 32'h1000, 32'h500, 32'h900, 32'hA00, 32'h0);
        chk("R2 higher level taken", {31'd0, taken}, 32'd1);
        chk("R1 mask loaded", {16'd0, sr_out}, 32'h2500);
        chk("R6 hw fmt word", rd16(32'h8FE), 32'h0074);
        chk("R3 hw old sr", rd16(32'h8F8), 32'h2200);
        chk("R9 hw pc_out", pc_out, 32'h0E00);
    endtask

    task automatic t_master();
        clr_mem();
        wr32(32'h170, 32'h0000_0F00);
        fire(0, 1, 3'd4, 8'd28, 16'h3000, 32'h6000, 32'h500, 32'h900, 32'hA00, 32'h0);
        chk("R8 master fmt0 word", rd16(32'h9FE), 32'h0070);
        chk("R8 master pc", rd32(32'h9FA), 32'h6000);
        chk("R8 master old sr", rd16(32'h9F8), 32'h3000);
        chk("R8 msp_out", msp_out, 32'h9F8);
        chk("R8 int fmt1 word", rd16(32'h8FE), 32'h1070);
        chk("R8 int pc", rd32(32'h8FA), 32'h6000);
        chk("R8 int frame sr", rd16(32'h8F8), 32'h3400);
        chk("R8 isp_out", isp_out, 32'h8F8);
        chk("R8 final sr", {16'd0, sr_out}, 32'h2400);
        chk("R8 pc_out", pc_out, 32'h0F00);
    endtask

    task automatic t_rte_skip();
        logic [3:0]  fmts [5] = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd7};
        logic [31:0] ends [5] = '{32'h808, 32'h80C, 32'h80C, 32'h810, 32'h83C};
        for (int k = 0; k < 5; k++) begin
            clr_mem();
            wr16(32'h800, 16'h0010);
            wr32(32'h802, 32'h0000_7000 + 32'(k));
            wr16(32'h806, {fmts[k], 12'h018});
            fire(1, 0, 0, 8'd0, 16'h2000, 32'h0, 32'h500, 32'h800, 32'hA00, 32'h0);
            chk("R10 rte isp_out", isp_out, ends[k]);
            chk("R10 rte sr_out", {16'd0, sr_out}, 32'h0010);
            chk("R10 rte pc_out", pc_out, 32'h0000_7000 + 32'(k));
            chk("R10 rte usp kept", usp_out, 32'h500);
        end
    endtask

    task automatic t_rte_fmt1();
        clr_mem();
        wr16(32'hA00, 16'h2000);
        wr32(32'hA02, 32'h0000_1111);
        wr16(32'hA06, 16'h1070);
        wr16(32'h900, 16'h0008);
        wr32(32'h902, 32'h0000_8888);
        wr16(32'h906, 16'h0000);
        fire(1, 0, 0, 8'd0, 16'h3000, 32'h0, 32'h500, 32'h900, 32'hA00, 32'h0);
        chk("R11 msp_out", msp_out, 32'hA08);
        chk("R11 isp_out", isp_out, 32'h908);
        chk("R11 sr_out", {16'd0, sr_out}, 32'h0008);
        chk("R11 pc_out", pc_out, 32'h8888);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trap();
        t_div0();
        t_addr_err();
        t_fmt4();
        t_decline();
        t_hw();
        t_master();
        t_rte_skip();
        t_rte_fmt1();
        chk("R12 address held during waits", 32'(hold_err), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule